// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is an eight-bit register (width set by a parameter) that, on each rising clock edge, does one of four things: keep its value, move its bits one place toward the top, move them one place toward the bottom, or take a new word from a parallel bus. A two-bit mode input picks the operation.

Parallel data goes in and out on one bidirectional bus. The register puts its contents on the bus only when both active-low enables are low and the mode is not load. In every other case it leaves the bus floating, so another device can drive it.

The bottom and top bits also drive two serial outputs that are never released. Each shift direction has its own serial input. Registers can be chained through these pins to make longer words. An active-low reset clears the register at once, without waiting for a clock edge.

Top module: `ushift_reg`

## Requirements
- R1: While `rst_n` is low the register is zero at once, without a clock edge, whatever `mode_sel` and the clock do.
- R2: With `mode_sel` = 2'b00 (hold), the contents stay the same across rising edges.
- R3: With `mode_sel` = 2'b01 (shift up), bit i+1 takes bit i on a rising edge, and bit 0 takes `ser_rin`.
- R4: With `mode_sel` = 2'b10 (shift down), bit i takes bit i+1 on a rising edge, and the top bit takes `ser_lin`.
- R5: With `mode_sel` = 2'b11 (load), the register takes the value on `pbus` at the rising edge.
- R6: When `oe_a_n` and `oe_b_n` are both low and the mode is not load, `pbus` carries the register contents.
- R7: When `oe_a_n` or `oe_b_n` is high, the block releases all bits of `pbus`.
- R8: In load mode the block releases `pbus`, whatever the enables are.
- R9: `tail_lo` always equals bit 0 and `tail_hi` always equals the top bit, even while the bus is released.
- R10: Two instances make one shift register of twice the width when they are chained like this: the low stage's `tail_hi` feeds the high stage's `ser_rin`, and the high stage's `tail_lo` feeds the low stage's `ser_lin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | Operation select: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_rin | input | 1 | Serial bit entering bit 0 on shift up |
| ser_lin | input | 1 | Serial bit entering the top bit on shift down |
| oe_a_n | input | 1 | Bus output enable, active low |
| oe_b_n | input | 1 | Bus output enable, active low |
| pbus | inout | W | Parallel bus: register contents out, load data in |
| tail_lo | output | 1 | Bit 0 of the register |
| tail_hi | output | 1 | Top bit of the register |

## Verification
The bench tests two chained instances against a sixteen-bit reference model. A pullup on each bus makes a floating bus read as all ones, so a released bus can be told apart from a driven one. Directed runs cover these cases:
- A load followed by sixteen shifts in each direction. This separates a wrong fill bit, a wrong direction and a broken chain link.
- Holds under all four enable combinations. These show whether the bus is released per enable and whether the tail pins stay live.
- A reset asserted in the middle of a clock phase. This proves the clear does not wait for an edge.

Random cycles then mix all modes, serial bits, enables and load words. This catches interactions the directed cases miss, such as a load that ignores the enables or a hold that leaks a shift.

// File: rtl/ushift_reg.sv
module ushift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode_sel,
  input  logic         ser_rin,
  input  logic         ser_lin,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  inout  wire  [W-1:0] pbus,
  output logic         tail_lo,
  output logic         tail_hi
);
  localparam logic [1:0] M_HOLD = 2'b00;
  localparam logic [1:0] M_UP   = 2'b01;
  localparam logic [1:0] M_DOWN = 2'b10;
  localparam logic [1:0] M_LOAD = 2'b11;

  logic [W-1:0] q;
  logic         drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else begin
      case (mode_sel)
        M_UP:    q <= {q[W-2:0], ser_rin};
        M_DOWN:  q <= {ser_lin, q[W-1:1]};
        M_LOAD:  q <= pbus;
        default: q <= q;
      endcase
    end
  end

  assign drive   = !oe_a_n && !oe_b_n && (mode_sel != M_LOAD);
  assign pbus    = drive ? q : {W{1'bz}};
  assign tail_lo = q[0];
  assign tail_hi = q[W-1];

  // R1: the register reads zero at every edge seen while the clear is held
  a_r1_clear: assert property (@(posedge clk) !rst_n |-> (q == '0));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == M_HOLD) |=> $stable(q));

  a_r3_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == M_UP) |=> (q == {$past(q[W-2:0]), $past(ser_rin)}));

  a_r4_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == M_DOWN) |=> (q == {$past(ser_lin), $past(q[W-1:1])}));

  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == M_LOAD) |=> (q == $past(pbus)));
endmodule

// File: tb/ushift_reg_tb_top.sv
module ushift_reg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic sr = 1'b0, sl = 1'b0, oea = 1'b0, oeb = 1'b0;
  logic tb_drv = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] model = '0;
  int checks = 0, fails = 0;

  wire [7:0] bus_a, bus_b;
  wire lo_a, hi_a, lo_b, hi_b;

  for (genvar i = 0; i < 8; i++) begin : g_pu
    pullup pa (bus_a[i]);
    pullup pb (bus_b[i]);
  end
  assign bus_a = tb_drv ? din[7:0]  : 8'bz;
  assign bus_b = tb_drv ? din[15:8] : 8'bz;

  always #4 clk = ~clk;

  ushift_reg #(.W(8)) dut_i (.clk(clk), .rst_n(rst_n), .mode_sel(mode),
    .ser_rin(sr), .ser_lin(lo_b), .oe_a_n(oea), .oe_b_n(oeb),
    .pbus(bus_a), .tail_lo(lo_a), .tail_hi(hi_a));
  ushift_reg #(.W(8)) dut_hi (.clk(clk), .rst_n(rst_n), .mode_sel(mode),
    .ser_rin(hi_a), .ser_lin(sl), .oe_a_n(oea), .oe_b_n(oeb),
    .pbus(bus_b), .tail_lo(lo_b), .tail_hi(hi_b));

  function automatic logic [15:0] next_val(logic [15:0] v, logic [1:0] m,
                                           logic r, logic l, logic [15:0] d);
    case (m)
      2'b01:   return {v[14:0], r};
      2'b10:   return {l, v[15:1]};
      2'b11:   return d;
      default: return v;
    endcase
  endfunction

  function automatic logic [15:0] bus_expect(logic [15:0] v, logic [1:0] m,
                                             logic a, logic b, logic [15:0] d);
    if (m == 2'b11) return d;
    if (a || b) return 16'hFFFF;
    return v;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    check({tag, " bus"}, {bus_b, bus_a}, bus_expect(model, mode, oea, oeb, din));
    check("R9 tails", {12'h0, hi_b, lo_b, hi_a, lo_a},
          {12'h0, model[15], model[8], model[7], model[0]});
  endtask

  task automatic step(string tag, logic [1:0] m, logic r, logic l,
                      logic a, logic b, logic [15:0] d);
    @(negedge clk);
    mode = m; sr = r; sl = l; oea = a; oeb = b; din = d;
    tb_drv = (m == 2'b11);
    @(posedge clk);
    model = next_val(model, m, r, l, d);
    #2;
    check_outs(tag);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] pat;
    void'($urandom(32'd2024));
    #10;
    check("R1 reset", {bus_b, bus_a}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    step("R5 R6 R8 load", 2'b11, 0, 0, 0, 0, 16'hA5C3);
    step("R6 show", 2'b00, 0, 0, 0, 0, '0);
    pat = 16'h3C96;
    for (int i = 0; i < 16; i++) step("R3 R10 shift up", 2'b01, pat[i], 0, 0, 0, '0);
    check("R3 R10 full word up", model, pat_rev(pat));

    step("R5 R8 load oe high", 2'b11, 0, 0, 1, 1, 16'h1E0F);
    for (int i = 0; i < 16; i++) step("R4 R10 shift down", 2'b10, 0, pat[i], 0, 0, '0);
    check("R4 R10 full word down", model, pat);

    for (int e = 0; e < 4; e++) begin
      step("R2 R7 hold oe combo", 2'b00, 1, 1, e[0], e[1], '0);
      step("R2 R7 hold again", 2'b00, 0, 1, e[0], e[1], '0);
    end

    step("R3 pre-reset", 2'b01, 1, 0, 0, 0, '0);
    step("R3 pre-reset", 2'b01, 0, 0, 0, 0, '0);
    #1 rst_n = 1'b0;
    #1 model = '0;
    check("R1 async clear", {bus_b, bus_a}, 16'h0000);
    @(posedge clk); #1;
    check("R1 clear holds over edge", {bus_b, bus_a}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < 400; k++) begin
      logic [1:0] m;
      m = 2'($urandom);
      step("R2-mix random", m, 1'($urandom), 1'($urandom),
           ($urandom % 4) == 0, ($urandom % 4) == 0, 16'($urandom));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic [15:0] pat_rev(logic [15:0] p);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[15 - i] = p[i];
    return r;
  endfunction
endmodule